// File: doc/BRIEF.md
# Serial Double-Length Accumulator

This block is the accumulator of a bit-serial machine. Its content is a double-length word of 72 binary digits: a high word and a low word of 36 digits each. Both words circulate continuously through shift-register loops, one digit per clock, least significant digit first. The low word circulates through a plain 36-stage loop. The high word circulates through a 32-stage store, a two-stage shifting section and a two-stage serial adder section. Together these make one full word period of 36 clocks, so the high word stays aligned with the low word.

Time is divided into words of 36 digit periods. A free-running digit counter marks them. A command is taken through a valid/ready handshake and acts on the whole of the next word. Back-pressure works as follows. `cmd_ready` rises only in the last digit period of a word. A requester keeps `cmd_valid` and `cmd_op` steady until it sees `cmd_ready` high at a clock edge, and the command is taken at that edge. A word that starts with no command taken leaves the content unchanged.

The store stream has no back-pressure: the loops cannot pause. Its sink must take a digit on every clock in which `out_valid` is high. The serial operand for add and subtract is a timed pin: digit d of the operand is sampled in digit period d of the command's word.

Top module: `serial_dbl_acc`

## Requirements
- R1: After reset the digit counter is 0, `sign` is 0, `out_valid` is 0, `cmd_ready` is 0, and both words hold zero.
- R2: `digit` counts 0 to 35 and then wraps to 0. `word_start` is high at digit 0. `cmd_ready` is high only at digit 35. A command taken at that edge acts on digits 0 to 35 of the word that follows.
- R3: Command codes are 4 bits wide. Code 0 (hold), codes 9 to 15, and words with no command taken all leave both words unchanged and ignore `opnd_bit`.
- R4: Code 1 (add) sets high = high + operand, modulo 2^36, with the operand taken from `opnd_bit` least significant digit first.
- R5: Code 2 (subtract) sets high = high - operand, modulo 2^36.
- R6: Code 3 (clear) sets both words to zero.
- R7: Code 4 shifts the 72-digit value {high, low} left by one place. Low digit 0 receives 0, and high digit 0 receives the old low digit 35.
- R8: Code 5 shifts {high, low} right by one place, arithmetically. High digit 35 is kept, and low digit 35 receives the old high digit 0.
- R9: `sign` is high digit 35 of the value written during the most recent word. It is updated at the end of each word and can be read from digit 0 of the next word.
- R10: Code 6 (store) raises `out_valid` for digits 0 to 35 of its word and puts high digit d on `out_bit` in digit period d, except that digit 0 is forced to 0.
- R11: Code 7 (short store) behaves like code 6, but also forces digit 18 to 0.
- R12: Code 8 (store low) streams the low word in the same way as code 6, with digit 0 forced to 0.
- R13: The store codes (6, 7, 8) leave both words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Digit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command is taken at this edge (last digit of a word) |
| cmd_op | input | 4 | Command code |
| opnd_bit | input | 1 | Serial operand digit for add or subtract |
| sign | output | 1 | High word is negative |
| word_start | output | 1 | Digit 0 of a word |
| digit | output | 6 | Current digit position |
| out_valid | output | 1 | Store stream digit present |
| out_bit | output | 1 | Store stream digit |

## Verification
The bench goes after the seams of the word. One target is carry across the wrap from digit 35 back to digit 0: an adder that does not reset its carry at digit 0 leaks a carry into the next word's least significant digit. A second target is shifts across the tank boundary. A design that fills zeros instead of crossing bits between the words loses the odd bit on a right shift and fails to restore it on a left shift. A design that reads the right-shift tap at digit 35 picks up freshly written data instead of copying the sign. The bench also places values with digits 0 and 18 set under both kinds of store, which exposes a missing or misplaced inhibit. It sends hold and unused codes with a noisy operand pin, which shows any block that lets the operand leak into the content.

// File: rtl/sda_pkg.sv
package sda_pkg;
  typedef enum logic [3:0] {
    OP_HOLD        = 4'd0,
    OP_ADD         = 4'd1,
    OP_SUB         = 4'd2,
    OP_CLR         = 4'd3,
    OP_SHL         = 4'd4,
    OP_SHR         = 4'd5,
    OP_STORE       = 4'd6,
    OP_STORE_SHORT = 4'd7,
    OP_STORE_LOW   = 4'd8
  } sda_op_e;

  // Which tap of the shifting section feeds the adder.
  typedef enum logic [1:0] {
    TAP_NORM = 2'd0,  // two digit-times: value unchanged
    TAP_UP   = 2'd1,  // one digit-time later: value doubled
    TAP_DOWN = 2'd2   // one digit-time earlier: value halved
  } tap_e;

  localparam int unsigned LOOP_STAGES = 4;  // shifting + adder digit-times
endpackage

// File: rtl/sda_digit_ctr.sv
module sda_digit_ctr #(
  parameter int unsigned WORD_W = 36,
  localparam int unsigned DW = $clog2(WORD_W)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] digit,
  output logic          first,
  output logic          last
);
  assign first = (digit == '0);
  assign last  = (digit == DW'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    digit <= '0;
    else if (last) digit <= '0;
    else           digit <= digit + 1'b1;
  end

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> first);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> digit == $past(digit) + 1'b1);
endmodule

// File: rtl/sda_hi_loop.sv
module sda_hi_loop
  import sda_pkg::*;
#(
  parameter int unsigned WORD_W = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic first,
  input  logic last,
  input  tap_e tap,
  input  logic up_fill,    // digit entering position 0 on a left shift
  input  logic arith_en,
  input  logic sub,
  input  logic clear,
  input  logic opnd_bit,
  output logic cur_bit,    // present digit at the normal tap
  output logic sign
);
  localparam int unsigned TANK_LEN = WORD_W - LOOP_STAGES;

  logic [TANK_LEN-1:0] tank;
  logic sh0, sh1, sh2;   // shifting section (sh2 is the extra late tap)
  logic ad0, ad1;        // adder section
  logic carry, sign_q;
  logic a, b, cin, sum, cout;

  always_comb begin
    unique case (tap)
      TAP_UP:   a = first ? up_fill : sh2;
      TAP_DOWN: a = last  ? sh1     : sh0;
      default:  a = sh1;
    endcase
    b    = arith_en & (opnd_bit ^ sub);
    cin  = arith_en & (first ? sub : carry);
    sum  = ~clear & (a ^ b ^ cin);
    cout = (a & b) | (a & cin) | (b & cin);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tank   <= '0;
      sh0    <= 1'b0;
      sh1    <= 1'b0;
      sh2    <= 1'b0;
      ad0    <= 1'b0;
      ad1    <= 1'b0;
      carry  <= 1'b0;
      sign_q <= 1'b0;
    end else begin
      tank  <= {ad1, tank[TANK_LEN-1:1]};
      sh0   <= tank[0];
      sh1   <= sh0;
      sh2   <= sh1;
      ad0   <= sum;
      ad1   <= ad0;
      carry <= cout;
      if (last) sign_q <= sum;
    end
  end

  assign cur_bit = sh1;
  assign sign    = sign_q;

  // R13
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arith_en && !clear && tap == TAP_NORM) |=> ad0 == $past(sh1));
  // R6
  clear_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && last) |=> !sign);
endmodule

// File: rtl/sda_lo_tank.sv
module sda_lo_tank
  import sda_pkg::*;
#(
  parameter int unsigned WORD_W = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic first,
  input  logic last,
  input  tap_e tap,
  input  logic clear,
  input  logic down_fill,  // digit entering position 35 on a right shift
  output logic cur_bit,
  output logic prev_bit    // digit one position below the current one
);
  logic [WORD_W-1:0] q;
  logic prev_q, nxt;

  always_comb begin
    unique case (tap)
      TAP_UP:   nxt = first ? 1'b0 : prev_q;
      TAP_DOWN: nxt = last ? down_fill : q[1];
      default:  nxt = q[0];
    endcase
    if (clear) nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q      <= '0;
      prev_q <= 1'b0;
    end else begin
      q      <= {nxt, q[WORD_W-1:1]};
      prev_q <= q[0];
    end
  end

  assign cur_bit  = q[0];
  assign prev_bit = prev_q;
endmodule

// File: rtl/serial_dbl_acc.sv
module serial_dbl_acc
  import sda_pkg::*;
#(
  parameter int unsigned WORD_W      = 36,
  parameter int unsigned SHORT_DIGIT = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [3:0]                 cmd_op,
  input  logic                       opnd_bit,
  output logic                       sign,
  output logic                       word_start,
  output logic [$clog2(WORD_W)-1:0]  digit,
  output logic                       out_valid,
  output logic                       out_bit
);
  localparam int unsigned DW = $clog2(WORD_W);

  logic first, last;
  sda_op_e op_q;
  tap_e tap;
  logic arith_en, sub, clear;
  logic hi_cur, lo_cur, lo_prev, hi_d0;
  logic st_hi, st_lo, inhibit;

  sda_digit_ctr #(.WORD_W(WORD_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .digit(digit), .first(first), .last(last)
  );

  assign cmd_ready  = last;
  assign word_start = first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= OP_HOLD;
      hi_d0 <= 1'b0;
    end else begin
      if (last)
        op_q <= (cmd_valid && cmd_op <= 4'd8) ? sda_op_e'(cmd_op) : OP_HOLD;
      if (first) hi_d0 <= hi_cur;
    end
  end

  always_comb begin
    arith_en = (op_q == OP_ADD) || (op_q == OP_SUB);
    sub      = (op_q == OP_SUB);
    clear    = (op_q == OP_CLR);
    tap      = (op_q == OP_SHL) ? TAP_UP :
               (op_q == OP_SHR) ? TAP_DOWN : TAP_NORM;
  end

  sda_hi_loop #(.WORD_W(WORD_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .first(first), .last(last), .tap(tap),
    .up_fill(lo_prev), .arith_en(arith_en), .sub(sub), .clear(clear),
    .opnd_bit(opnd_bit), .cur_bit(hi_cur), .sign(sign)
  );

  sda_lo_tank #(.WORD_W(WORD_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .first(first), .last(last), .tap(tap),
    .clear(clear), .down_fill(hi_d0), .cur_bit(lo_cur), .prev_bit(lo_prev)
  );

  always_comb begin
    st_hi     = (op_q == OP_STORE) || (op_q == OP_STORE_SHORT);
    st_lo     = (op_q == OP_STORE_LOW);
    out_valid = st_hi || st_lo;
    inhibit   = first ||
                ((op_q == OP_STORE_SHORT) && digit == DW'(SHORT_DIGIT));
    out_bit   = out_valid && !inhibit && (st_lo ? lo_cur : hi_cur);
  end

  // R2
  take_then_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> word_start);
  // R10
  digit0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && word_start) |-> !out_bit);
  // R11
  short_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_STORE_SHORT && digit == DW'(SHORT_DIGIT)) |-> !out_bit);
  // R10
  stream_whole_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> word_start);
endmodule

// File: tb/test_serial_dbl_acc.sv
module test_serial_dbl_acc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = 4'd0;
  logic       opnd_bit = 1'b0;
  logic       cmd_ready, sign, word_start, out_valid, out_bit;
  logic [5:0] digit;

  serial_dbl_acc i_serial_dbl_acc (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .opnd_bit(opnd_bit), .sign(sign),
    .word_start(word_start), .digit(digit), .out_valid(out_valid),
    .out_bit(out_bit)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [71:0] m = '0;   // reference {high, low}
  bit    exp_q[$];
  string tag_q[$];

  task automatic chk(string req, logic [71:0] act, logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_word(logic [35:0] w, bit short_st, string tag);
    for (int i = 0; i < 36; i++) begin
      exp_q.push_back((i == 0 || (short_st && i == 18)) ? 1'b0 : w[i]);
      tag_q.push_back(tag);
    end
  endtask

  // Driver: offer a command, wait for the handshake, then feed the operand.
  task automatic do_op(logic [3:0] op, logic [35:0] opnd);
    logic exp_sign;
    exp_sign  = m[71];
    cmd_valid = 1'b1;
    cmd_op    = op;
    while (!cmd_ready) @(negedge clk);
    case (op)
      4'd1: m[71:36] = m[71:36] + opnd;               // R4
      4'd2: m[71:36] = m[71:36] - opnd;               // R5
      4'd3: m = '0;                                   // R6
      4'd4: m = m << 1;                               // R7
      4'd5: m = 72'($signed(m) >>> 1);                // R8
      4'd6: push_word(m[71:36], 1'b0, "R10 store");
      4'd7: push_word(m[71:36], 1'b1, "R11 short store");
      4'd8: push_word(m[35:0], 1'b0, "R12 store low");
      default: ;                                      // R3 hold
    endcase
    for (int k = 0; k < 36; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (k == 0) begin
        chk("R9 sign", 72'(sign), 72'(exp_sign));
        chk("R2 word_start", 72'(word_start), 72'd1);
      end
      opnd_bit = opnd[digit];
    end
  endtask

  task automatic idle_word();
    cmd_valid = 1'b0;
    repeat (36) @(negedge clk);
  endtask

  // Monitor: scoreboard of the store stream.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R13 unexpected stream digit actual=%0b expected=none", out_bit);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 72'(out_bit), 72'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  localparam logic [35:0] NOISE = 36'hA5C3_96F1E;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1 digit", 72'(digit), 72'd0);
    chk("R1 sign", 72'(sign), 72'd0);
    chk("R1 out_valid", 72'(out_valid), 72'd0);
    chk("R1 cmd_ready", 72'(cmd_ready), 72'd0);
    do_op(4'd6, NOISE);                    // R1 high zero
    do_op(4'd8, NOISE);                    // R1 low zero
    do_op(4'd1, 36'h0_0004_0001);          // R4 digits 0 and 18 set
    do_op(4'd6, NOISE);                    // R10
    do_op(4'd7, NOISE);                    // R11
    do_op(4'd1, 36'h1_2345_6789);          // R4
    do_op(4'd1, 36'hF_FFFF_FFFF);          // R4 wrap
    do_op(4'd6, 36'd0);
    do_op(4'd2, 36'h8_0000_0000);          // R5 goes negative
    do_op(4'd6, 36'd0);                    // R9 sign seen here
    do_op(4'd0, NOISE);                    // R3
    do_op(4'd12, NOISE);                   // R3 unused code
    idle_word();                           // R3 no command
    do_op(4'd6, NOISE);                    // R13
    do_op(4'd5, NOISE);                    // R8
    do_op(4'd6, 36'd0);
    do_op(4'd8, 36'd0);
    do_op(4'd5, NOISE);                    // R8
    do_op(4'd8, 36'd0);
    do_op(4'd4, NOISE);                    // R7 crosses from low
    do_op(4'd6, 36'd0);
    do_op(4'd8, 36'd0);
    do_op(4'd4, NOISE);                    // R7
    do_op(4'd7, 36'd0);
    do_op(4'd3, NOISE);                    // R6
    do_op(4'd6, NOISE);
    do_op(4'd8, NOISE);
    do_op(4'd2, 36'd1);                    // R5 zero minus one
    do_op(4'd5, 36'd0);                    // R8 sign kept
    do_op(4'd6, 36'd0);
    do_op(4'd8, 36'd0);
    do_op(4'd1, 36'd1);                    // R4 carry through all digits
    do_op(4'd6, 36'd0);
    do_op(4'd0, 36'd0);
    chk("R13 stream drained", 72'(exp_q.size()), 72'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule